// File: doc/BRIEF.md
# Serial Clock Timing Generator

This block derives the serial clock of a half-duplex serial flash port from a faster bus clock. A 4-bit counter steps through a programmable period measured in bus-clock cycles, and two further programmable positions within that period say where the serial clock falls and where it rises. The clock idles high, so the falling edge is where a command engine launches the next bit and the rising edge is where the flash expects it to be stable. A third position picks the bus-clock cycle in which read data is sampled.

A command engine raises `enable` to start the clock and watches `busy`. Dropping `enable` lets the current period finish; the clock then parks high and `busy` clears. Two single-cycle strobes, one on the falling edge and one at the sample position, tell the engine when to shift data out and when to capture data in. A combinational helper turns a requested maximum rate in MHz into a source-clock choice, a divisor and a ready-to-load timing word.

Top module: `sclk_timing_gen`

## Requirements
- R1: While reset is asserted and after reset releases, `sclkOut` is 1 and `busy`, `launchStb` and `sampleStb` are 0.
- R2: When idle and `enable` is 1 at a clock edge, `busy` is 1 from that edge on and the position counter restarts at 0.
- R3: The period field is `cfgTiming[3:0]`; the counter counts 0 up to P-1 and wraps, where P is the field value, or 2 when the field is below 2.
- R4: The falling position is `cfgTiming[15:12]`; one edge after the counter equals it, `sclkOut` is 0 and `launchStb` is 1 for exactly one cycle (no launch pulse on the stopping edge).
- R5: The rising position is `cfgTiming[11:8]`; one edge after the counter equals it, `sclkOut` is 1, except that when rising and falling positions are equal the fall wins and the clock stays low.
- R6: The sample position is `cfgTiming[19:16]`; one edge after the counter equals it while running, `sampleStb` is 1 for one cycle.
- R7: If `enable` is 0 on the edge where the counter wraps, `busy` drops on that edge, `sclkOut` returns to 1, and no strobe is raised while idle; `enable` dropping at any other point has no effect until the wrap.
- R8: A position field equal to or above the effective period never produces an edge or strobe.
- R9: When `reqRateMhz` is 100 or more, `srcFast` is 1 and `divisor` is 1.
- R10: Below 100, `srcFast` is 0 and `divisor` is the smallest i in 1..6 with 50 <= i * `reqRateMhz`, or 7 if no such i exists.
- R11: `suggestTiming` holds period 2*`divisor` in bits [3:0], rising position `divisor` in bits [11:8], falling position 0 in bits [15:12], sample position `divisor` in bits [19:16], and zero elsewhere.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Request to run the serial clock |
| cfgTiming | input | 20 | Timing word: period, rising, falling and sample positions |
| reqRateMhz | input | 8 | Requested maximum serial rate in MHz |
| busy | output | 1 | Serial clock is running |
| sclkOut | output | 1 | Serial clock, idles high |
| launchStb | output | 1 | One-cycle pulse with each falling edge |
| sampleStb | output | 1 | One-cycle pulse at the sample position |
| srcFast | output | 1 | 1 selects the 100 MHz source, 0 the 50 MHz one |
| divisor | output | 3 | Selected divisor, 1 to 7 |
| suggestTiming | output | 20 | Timing word derived from the divisor |

## Verification
The clock path is swept over every period value against every combination of rising and falling positions from 0 to 7, which covers normal placements, coincident rise and fall, and positions beyond the period; a cycle-level model in the bench separates a wrong wrap point from a wrong edge or strobe latency. Each divisor-derived word from 1 to 7 is run and its low and high phase lengths and launch spacing are counted, telling apart half-period errors from whole-period ones. A mid-period `enable` drop checks that stopping waits for the wrap. Every requested rate from 0 to 255 is applied to the helper, which exercises each threshold of the division search including the fallback to 7.

// File: rtl/sclk_pkg.sv
`timescale 1ns/1ps
package sclk_pkg;
  localparam int POS_W  = 4;
  localparam int WORD_W = 5 * POS_W;

  typedef logic [POS_W-1:0] pos_t;

  // Field order follows the bit layout of the timing word, msb first.
  typedef struct packed {
    pos_t sample;
    pos_t fall;
    pos_t rise;
    pos_t spare;
    pos_t period;
  } timing_t;

  // Strobes from the sequencing control to the clock datapath.
  typedef struct packed {
    logic atFall;
    logic atRise;
    logic atSample;
    logic stopNow;
  } ctrl_strobe_t;

  function automatic timing_t unpackTiming(input logic [WORD_W-1:0] w);
    return timing_t'(w);
  endfunction

  function automatic logic [WORD_W-1:0] packTiming(input timing_t t);
    return WORD_W'(t);
  endfunction
endpackage

// File: rtl/sclk_div_select.sv
`timescale 1ns/1ps
module sclk_div_select import sclk_pkg::*; #(
  parameter int RATE_W    = 8,
  parameter int FAST_MHZ  = 100,
  parameter int SLOW_MHZ  = 50,
  parameter int DIV_STEPS = 6,
  localparam int DIV_W    = $clog2(DIV_STEPS + 2)
) (
  input  logic [RATE_W-1:0] reqRateMhz,
  output logic              srcFast,
  output logic [DIV_W-1:0]  divisor,
  output logic [WORD_W-1:0] suggestTiming
);
  localparam int PROD_W = RATE_W + DIV_W;
  localparam logic [PROD_W-1:0] SLOW_L = PROD_W'(SLOW_MHZ);
  localparam logic [RATE_W-1:0] FAST_L = RATE_W'(FAST_MHZ);

  logic [DIV_STEPS:1] fits;
  logic [DIV_W-1:0]   slowDiv;
  timing_t            sugg;

  // One comparator per candidate divisor: slow source / i <= rate.
  for (genvar g = 1; g <= DIV_STEPS; g++) begin : g_fit
    logic [PROD_W-1:0] scaled;
    assign scaled = PROD_W'(reqRateMhz) * PROD_W'(g);
    assign fits[g] = (SLOW_L <= scaled);
  end

  // Smallest qualifying divisor wins; fall back to one past the last step.
  always_comb begin
    slowDiv = DIV_W'(DIV_STEPS + 1);
    for (int k = DIV_STEPS; k >= 1; k--) begin
      if (fits[k]) slowDiv = DIV_W'(k);
    end
  end

  always_comb begin
    srcFast = (reqRateMhz >= FAST_L);
    divisor = srcFast ? DIV_W'(1) : slowDiv;
  end

  always_comb begin
    sugg        = '0;
    sugg.period = POS_W'({divisor, 1'b0});
    sugg.rise   = POS_W'(divisor);
    sugg.fall   = '0;
    sugg.sample = POS_W'(divisor);
    suggestTiming = packTiming(sugg);
  end
endmodule

// File: rtl/sclk_ctrl.sv
`timescale 1ns/1ps
module sclk_ctrl import sclk_pkg::*; (
  input  logic         clk,
  input  logic         rstN,
  input  logic         enable,
  input  pos_t         periodCfg,
  input  pos_t         risePos,
  input  pos_t         fallPos,
  input  pos_t         samplePos,
  output logic         running,
  output ctrl_strobe_t stb
);
  pos_t cnt;
  pos_t lastCnt;
  logic atWrap;

  // Periods below two cycles are stretched to two.
  always_comb begin
    lastCnt = (periodCfg < POS_W'(2)) ? POS_W'(1) : periodCfg - 1'b1;
    atWrap  = running && (cnt == lastCnt);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (!running) begin
      if (enable) begin
        running <= 1'b1;
        cnt     <= '0;
      end
    end else if (atWrap) begin
      cnt <= '0;
      if (!enable) running <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    stb.atFall   = running && (cnt == fallPos);
    stb.atRise   = running && (cnt == risePos);
    stb.atSample = running && (cnt == samplePos);
    stb.stopNow  = atWrap && !enable;
  end
endmodule

// File: rtl/sclk_datapath.sv
`timescale 1ns/1ps
module sclk_datapath import sclk_pkg::*; (
  input  logic         clk,
  input  logic         rstN,
  input  ctrl_strobe_t stb,
  output logic         sclkOut,
  output logic         launchStb,
  output logic         sampleStb
);
  // Stop parks high and overrides both edges; a fall beats a rise.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkOut   <= 1'b1;
      launchStb <= 1'b0;
      sampleStb <= 1'b0;
    end else begin
      launchStb <= stb.atFall && !stb.stopNow;
      sampleStb <= stb.atSample;
      if (stb.stopNow)     sclkOut <= 1'b1;
      else if (stb.atFall) sclkOut <= 1'b0;
      else if (stb.atRise) sclkOut <= 1'b1;
    end
  end
endmodule

// File: rtl/sclk_timing_gen.sv
`timescale 1ns/1ps
module sclk_timing_gen import sclk_pkg::*; #(
  parameter int RATE_W    = 8,
  parameter int FAST_MHZ  = 100,
  parameter int SLOW_MHZ  = 50,
  parameter int DIV_STEPS = 6
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              enable,
  input  logic [WORD_W-1:0]                 cfgTiming,
  input  logic [RATE_W-1:0]                 reqRateMhz,
  output logic                              busy,
  output logic                              sclkOut,
  output logic                              launchStb,
  output logic                              sampleStb,
  output logic                              srcFast,
  output logic [$clog2(DIV_STEPS + 2)-1:0]  divisor,
  output logic [WORD_W-1:0]                 suggestTiming
);
  timing_t      cfg;
  ctrl_strobe_t stb;
  logic         unusedSpare;

  assign cfg         = unpackTiming(cfgTiming);
  assign unusedSpare = ^cfg.spare;

  sclk_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .periodCfg (cfg.period),
    .risePos   (cfg.rise),
    .fallPos   (cfg.fall),
    .samplePos (cfg.sample),
    .running   (busy),
    .stb       (stb)
  );

  sclk_datapath i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .sclkOut   (sclkOut),
    .launchStb (launchStb),
    .sampleStb (sampleStb)
  );

  sclk_div_select #(
    .RATE_W    (RATE_W),
    .FAST_MHZ  (FAST_MHZ),
    .SLOW_MHZ  (SLOW_MHZ),
    .DIV_STEPS (DIV_STEPS)
  ) i_div (
    .reqRateMhz    (reqRateMhz),
    .srcFast       (srcFast),
    .divisor       (divisor),
    .suggestTiming (suggestTiming)
  );
endmodule

// File: rtl/sclk_timing_chk.sv
`timescale 1ns/1ps
module sclk_timing_chk #(
  parameter int RATE_W    = 8,
  parameter int FAST_MHZ  = 100,
  parameter int DIV_STEPS = 6
) (
  input logic                             clk,
  input logic                             rstN,
  input logic                             enable,
  input logic [RATE_W-1:0]                reqRateMhz,
  input logic                             busy,
  input logic                             sclkOut,
  input logic                             launchStb,
  input logic                             sampleStb,
  input logic                             srcFast,
  input logic [$clog2(DIV_STEPS + 2)-1:0] divisor
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) !rstN |=> sclkOut && !busy);

  // R2
  start_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy && enable |=> busy);

  // R4
  launch_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    launchStb |-> !sclkOut);

  // R4
  launch_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    launchStb |=> !launchStb);

  // R7
  stop_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> sclkOut);

  // R7
  stop_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> !$past(enable));

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy && !$past(busy) |-> sclkOut && !launchStb && !sampleStb);

  // R9
  fast_div_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqRateMhz >= RATE_W'(FAST_MHZ) |-> srcFast && divisor == 1);

  // R10
  slow_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    !srcFast |-> divisor >= 1 && 32'(divisor) <= DIV_STEPS + 1);
endmodule

bind sclk_timing_gen sclk_timing_chk #(
  .RATE_W    (RATE_W),
  .FAST_MHZ  (FAST_MHZ),
  .DIV_STEPS (DIV_STEPS)
) i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .enable     (enable),
  .reqRateMhz (reqRateMhz),
  .busy       (busy),
  .sclkOut    (sclkOut),
  .launchStb  (launchStb),
  .sampleStb  (sampleStb),
  .srcFast    (srcFast),
  .divisor    (divisor)
);

// File: tb/test_sclk_timing_gen.sv
`timescale 1ns/1ps
module test_sclk_timing_gen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic [19:0] cfgTiming = '0;
  logic [7:0]  reqRateMhz = '0;
  logic        busy, sclkOut, launchStb, sampleStb, srcFast;
  logic [2:0]  divisor;
  logic [19:0] suggestTiming;

  int total = 0;
  int fails = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  sclk_timing_gen i_sclk_timing_gen (
    .clk(clk), .rstN(rstN), .enable(enable), .cfgTiming(cfgTiming),
    .reqRateMhz(reqRateMhz), .busy(busy), .sclkOut(sclkOut),
    .launchStb(launchStb), .sampleStb(sampleStb), .srcFast(srcFast),
    .divisor(divisor), .suggestTiming(suggestTiming)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Cycle model built from R2-R8.
  logic       mRun, mSclk, mL, mS;
  logic [3:0] mCnt;
  always @(posedge clk or negedge rstN) begin
    logic [3:0] last;
    logic hitF, hitR, hitS, stop;
    if (!rstN) begin
      mRun <= 0; mCnt <= 0; mSclk <= 1; mL <= 0; mS <= 0;
    end else begin
      last = (cfgTiming[3:0] < 2) ? 4'd1 : cfgTiming[3:0] - 4'd1;
      if (mRun) begin
        hitF = (mCnt == cfgTiming[15:12]);
        hitR = (mCnt == cfgTiming[11:8]);
        hitS = (mCnt == cfgTiming[19:16]);
        stop = (mCnt == last) && !enable;
        mL <= hitF && !stop;
        mS <= hitS;
        if (stop) mSclk <= 1;
        else if (hitF) mSclk <= 0;
        else if (hitR) mSclk <= 1;
        mCnt <= (mCnt == last) ? 4'd0 : mCnt + 4'd1;
        if (stop) mRun <= 0;
      end else begin
        mL <= 0; mS <= 0;
        if (enable) begin mRun <= 1; mCnt <= 0; end
      end
    end
  end

  bit compareOn = 0;
  int mism = 0;
  int firstAct, firstExp;
  always @(negedge clk) begin
    if (compareOn && ({busy, sclkOut, launchStb, sampleStb} !== {mRun, mSclk, mL, mS})) begin
      if (mism == 0) begin
        firstAct = int'({busy, sclkOut, launchStb, sampleStb});
        firstExp = int'({mRun, mSclk, mL, mS});
      end
      mism++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      check(0, "watchdog", cyc, 190000);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic waitIdle();
    for (int k = 0; k < 40 && busy; k++) @(negedge clk);
  endtask

  task automatic runCfg(input int p, input int r, input int f, input int s);
    int effP;
    @(negedge clk);
    cfgTiming = {4'(s), 4'(f), 4'(r), 4'h0, 4'(p)};
    mism = 0;
    compareOn = 1;
    enable = 1;
    effP = (p < 2) ? 2 : p;
    repeat (2 * effP + 1) @(negedge clk);
    enable = 0;
    waitIdle();
    repeat (2) @(negedge clk);
    compareOn = 0;
    if (mism != 0)
      $display("detail p=%0d r=%0d f=%0d s=%0d first {busy,sclk,launch,sample}", p, r, f, s);
    // R2 R3 R4 R5 R6 R7 R8
    check(mism == 0, "R2 R3 R4 R5 R6 R7 R8 model", firstAct, firstExp);
  endtask

  initial begin
    int n, lowN, highN, launchN, sampN, hiN;
    int d, expD;
    bit expFast;
    logic [19:0] expWord;

    repeat (2) @(negedge clk);
    // R1 during reset
    check(sclkOut && !busy && !launchStb && !sampleStb, "R1 in reset",
          int'({busy, sclkOut, launchStb, sampleStb}), 4);
    rstN = 1;
    repeat (2) @(negedge clk);
    // R1 after release
    check(sclkOut && !busy && !launchStb && !sampleStb, "R1 after reset",
          int'({busy, sclkOut, launchStb, sampleStb}), 4);

    // R9 R10 R11: every requested rate
    for (int r = 0; r < 256; r++) begin
      @(negedge clk);
      reqRateMhz = 8'(r);
      #1;
      expFast = (r >= 100);
      expD = 7;
      if (expFast) expD = 1;
      else for (int i = 6; i >= 1; i--) if (50 <= r * i) expD = i;
      expWord = {4'(expD), 4'h0, 4'(expD), 4'h0, 4'(2 * expD)};
      check(srcFast == expFast && divisor == 3'(expD), "R9 R10 divisor",
            int'({srcFast, divisor}), int'({expFast, 3'(expD)}));
      check(suggestTiming == expWord, "R11 word", int'(suggestTiming), int'(expWord));
    end

    // R3 R4 R5: phase lengths for each divisor-derived word
    for (int dd = 1; dd <= 7; dd++) begin
      d = dd;
      @(negedge clk);
      cfgTiming = {4'(d), 4'h0, 4'(d), 4'h0, 4'(2 * d)};
      enable = 1;
      for (int k = 0; k < 40 && sclkOut; k++) @(negedge clk);
      lowN = 0;
      while (!sclkOut && lowN < 40) begin lowN++; @(negedge clk); end
      highN = 0;
      while (sclkOut && highN < 40) begin highN++; @(negedge clk); end
      check(lowN == d, "R4 low phase", lowN, d);
      check(highN == d, "R5 high phase", highN, d);
      launchN = 0;
      for (int k = 0; k < 6 * d; k++) begin
        if (launchStb) launchN++;
        @(negedge clk);
      end
      check(launchN == 3, "R3 launch spacing", launchN, 3);
      enable = 0;
      waitIdle();
      check(sclkOut && !busy, "R7 parked high", int'({busy, sclkOut}), 1);
    end

    // R7: drop mid-period, stop waits for the wrap
    @(negedge clk);
    cfgTiming = {4'd5, 4'd0, 4'd5, 4'h0, 4'd10};
    enable = 1;
    repeat (13) @(negedge clk);
    enable = 0;
    n = 0;
    while (busy && n < 40) begin @(negedge clk); n++; end
    check(n == 8, "R7 stop at wrap", n, 8);
    check(sclkOut, "R7 high after stop", int'(sclkOut), 1);

    // R8: rise and sample beyond the period never fire
    @(negedge clk);
    cfgTiming = {4'd12, 4'd0, 4'd9, 4'h0, 4'd4};
    enable = 1;
    sampN = 0;
    hiN = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (sampleStb) sampN++;
      if (k >= 1 && sclkOut) hiN++;
    end
    enable = 0;
    check(sampN == 0, "R8 no sample", sampN, 0);
    check(hiN == 0, "R8 no rise", hiN, 0);
    waitIdle();

    // Model sweep: all periods, rise/fall 0..7
    for (int p = 0; p < 16; p++)
      for (int r = 0; r < 8; r++)
        for (int f = 0; f < 8; f++)
          runCfg(p, r, f, (r + f) % 16);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule